// File: doc/BRIEF.md
# Segmented DAC Switch-Control Front-End

This block sits between a sample stream and the array of current cells of a segmented current-steering converter. It accepts a binary word when `din_valid` is high and holds it in an input register. The upper `MSB_W` bits form a count. A thermometer decoder turns that count into enables for `2^MSB_W - 1` equal unit cells. The lower `LSB_W` bits switch the binary-weighted cells directly.

The unit cells can be switched on in either of two physical orders, chosen per word by `order_sel`:
- Ascending: positions 1, 2, 3 and so on.
- Centre-out: the middle position first, then one step below, then one step above, alternating outward. This spreads gradient errors evenly.

The decoder has one register stage. The binary bits pass through a dummy register of the same depth. Every control bit ends in its own retiming flop, so all cell switches change on one clock edge.

There is no control state machine. The block is a fixed three-register pipeline: the input register, the decode or dummy stage, and the cell retiming stage. It has two operating conditions:
- Accepting: `din_valid` is high and a new word enters.
- Holding: `din_valid` is low, the input register keeps its word, and the outputs settle to that word and stay there.

Top module: `segdac_frontend`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) forces every unit and binary enable to 0 after that edge. With the input register also cleared, the outputs stay 0 until a new word has passed through the pipeline.
- R2: The number of ones in `unit_en` equals the upper field `din[MSB_W+LSB_W-1:LSB_W]` of the word accepted three rising edges earlier. A count of 0 gives all cells off, and the maximum count gives all cells on.
- R3: With `order_sel` = 0 captured alongside the word, a count k sets exactly `unit_en[k-1:0]`. Bit index i drives physical position i+1.
- R4: With `order_sel` = 1 captured alongside the word, a count k sets the first k positions of the centre-out sequence. The sequence starts at position (N+1)/2, where N is the number of unit cells, then alternates one step lower and one step higher. For N = 7 this is 4, 3, 5, 2, 6, 1, 7, and bit index = position - 1.
- R5: `bin_en` equals the lower field `din[LSB_W-1:0]` of the word accepted three rising edges earlier.
- R6: A word sampled with `din_valid` high at edge e appears on both `unit_en` and `bin_en` right after edge e+2, never earlier. Both output groups change on that same edge.
- R7: While `din_valid` is low, `din` is ignored. The outputs settle to the last accepted word and keep it.
- R8: `order_sel` is captured only together with an accepted word. Changing it while `din_valid` is low has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers act on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din_valid | input | 1 | Load enable for the input register |
| din | input | MSB_W+LSB_W | Binary sample; upper field is the unit count, lower field drives the binary cells |
| order_sel | input | 1 | Unit switching order: 0 ascending, 1 centre-out |
| unit_en | output | 2^MSB_W-1 | Unit-cell enables; bit i is physical position i+1 |
| bin_en | output | LSB_W | Binary-cell enables; bit i has weight 2^i |

## Verification
On every cycle, the bound checker compares the outputs with the word accepted three edges earlier:
- the count of active unit cells;
- the binary enables;
- the exact ascending pattern;
- the first and next-to-last steps of the centre-out pattern.

It also checks that outputs freeze when no word enters, and that reset clears them.

Only the bench's sweeps show the full centre-out pattern at every count. The same applies to ignoring `order_sel` changes during a hold, to reset in the middle of a stream, and to the exact cycle at which each new word first appears.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_SYM = 1'b1
    } order_e;

    // Physical position (1-based) of the cell switched on at a given rank
    // (0-based) when the centre-out order is used over n cells.
    function automatic int sym_pos(input int rank, input int n);
        int c;
        c = (n + 1) / 2;
        if (rank == 0)
            return c;
        else if ((rank % 2) == 1)
            return c - (rank + 1) / 2;
        else
            return c + rank / 2;
    endfunction

endpackage

// File: rtl/segdac_retime.sv
module segdac_retime #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // One flop per control bit, cleared synchronously.
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= d;
    end

endmodule

// File: rtl/segdac_therm.sv
module segdac_therm #(
    parameter int MW = 3,
    localparam int N = (1 << MW) - 1
) (
    input  logic [MW-1:0] code,
    output logic [N-1:0]  therm
);

    // Rank r is on when the count exceeds r.
    for (genvar r = 0; r < N; r++) begin : g_rank
        assign therm[r] = (code > MW'(r));
    end

endmodule

// File: rtl/segdac_order_map.sv
module segdac_order_map
    import segdac_pkg::*;
#(
    parameter int N = 7
) (
    input  logic [N-1:0] therm,
    input  order_e       mode,
    output logic [N-1:0] vec
);

    logic [N-1:0] seq_v;
    logic [N-1:0] sym_v;

    // Route each rank to its physical position for both orders.
    for (genvar r = 0; r < N; r++) begin : g_rank
        localparam int P = sym_pos(r, N);
        assign seq_v[r]   = therm[r];
        assign sym_v[P-1] = therm[r];
    end

    always_comb begin
        unique case (mode)
            ORD_SEQ: vec = seq_v;
            ORD_SYM: vec = sym_v;
            default: vec = seq_v;
        endcase
    end

endmodule

// File: rtl/segdac_frontend.sv
module segdac_frontend
    import segdac_pkg::*;
#(
    parameter int MSB_W = 3,
    parameter int LSB_W = 3,
    localparam int DW = MSB_W + LSB_W,
    localparam int N  = (1 << MSB_W) - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          din_valid,
    input  logic [DW-1:0] din,
    input  logic          order_sel,
    output logic [N-1:0]  unit_en,
    output logic [LSB_W-1:0] bin_en
);

    logic [DW:0]        in_q;
    logic [N-1:0]       therm;
    logic [N-1:0]       map_v;
    order_e             mode;
    logic [N-1:0]       dec_q;
    logic [LSB_W-1:0]   lsb_q;
    logic [N+LSB_W-1:0] cell_q;

    // Stage 0: input register, loaded only with a valid word.
    segdac_retime #(.W(DW + 1)) u_in (
        .clk (clk),
        .rst (rst),
        .en  (din_valid),
        .d   ({order_sel, din}),
        .q   (in_q)
    );

    assign mode = order_e'(in_q[DW]);

    segdac_therm #(.MW(MSB_W)) u_therm (
        .code  (in_q[DW-1:LSB_W]),
        .therm (therm)
    );

    segdac_order_map #(.N(N)) u_map (
        .therm (therm),
        .mode  (mode),
        .vec   (map_v)
    );

    // Stage 1: decoder register and matching dummy delay on the binary bits.
    segdac_retime #(.W(N)) u_dec (
        .clk (clk),
        .rst (rst),
        .en  (1'b1),
        .d   (map_v),
        .q   (dec_q)
    );

    segdac_retime #(.W(LSB_W)) u_lsb_dly (
        .clk (clk),
        .rst (rst),
        .en  (1'b1),
        .d   (in_q[LSB_W-1:0]),
        .q   (lsb_q)
    );

    // Stage 2: per-cell retiming flops, all updated on one edge.
    segdac_retime #(.W(N + LSB_W)) u_cell (
        .clk (clk),
        .rst (rst),
        .en  (1'b1),
        .d   ({dec_q, lsb_q}),
        .q   (cell_q)
    );

    assign unit_en = cell_q[N+LSB_W-1:LSB_W];
    assign bin_en  = cell_q[LSB_W-1:0];

endmodule

// File: rtl/segdac_frontend_chk.sv
module segdac_frontend_chk #(
    parameter int MSB_W = 3,
    parameter int LSB_W = 3,
    localparam int DW = MSB_W + LSB_W,
    localparam int N  = (1 << MSB_W) - 1,
    localparam int C  = (N + 1) / 2
) (
    input logic             clk,
    input logic             rst,
    input logic             din_valid,
    input logic [DW-1:0]    din,
    input logic             order_sel,
    input logic [N-1:0]     unit_en,
    input logic [LSB_W-1:0] bin_en
);

    // Counts edges since reset release, saturating at 3.
    logic [1:0] warm_cnt;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)
            warm_cnt <= 2'd0;
        else if (warm_cnt != 2'd3)
            warm_cnt <= warm_cnt + 2'd1;
    end

    assign warm = (warm_cnt == 2'd3);

    function automatic logic [N-1:0] low_ones(input int k);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (i < k);
        return v;
    endfunction

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (unit_en == '0 && bin_en == '0));

    a_r2_unit_count: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(din_valid, 3)) |->
        ($countones(unit_en) == int'($past(din[DW-1:LSB_W], 3))));

    a_r3_seq_pattern: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(din_valid, 3) && !$past(order_sel, 3)) |->
        (unit_en == low_ones(int'($past(din[DW-1:LSB_W], 3)))));

    a_r4_sym_first: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(din_valid, 3) && $past(order_sel, 3) &&
         ($past(din[DW-1:LSB_W], 3) == MSB_W'(1))) |->
        (unit_en == (N'(1) << (C - 1))));

    a_r4_sym_last_off: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(din_valid, 3) && $past(order_sel, 3) &&
         ($past(din[DW-1:LSB_W], 3) == MSB_W'(N - 1))) |->
        (unit_en == ~(N'(1) << (N - 1))));

    a_r5_bin_field: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(din_valid, 3)) |->
        (bin_en == $past(din[LSB_W-1:0], 3)));

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (warm && !$past(din_valid, 3)) |->
        ($stable(unit_en) && $stable(bin_en)));

endmodule

bind segdac_frontend segdac_frontend_chk #(
    .MSB_W (MSB_W),
    .LSB_W (LSB_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .din_valid (din_valid),
    .din       (din),
    .order_sel (order_sel),
    .unit_en   (unit_en),
    .bin_en    (bin_en)
);

// File: tb/tb_segdac_frontend.sv
`timescale 1ns/1ps
module tb_segdac_frontend;

    localparam int MSB_W = 3;
    localparam int LSB_W = 3;
    localparam int DW    = MSB_W + LSB_W;
    localparam int N     = 7;
    localparam int SYM_SEQ [7] = '{4, 3, 5, 2, 6, 1, 7};

    logic             clk = 1'b0;
    logic             rst;
    logic             din_valid;
    logic [DW-1:0]    din;
    logic             order_sel;
    logic [N-1:0]     unit_en;
    logic [LSB_W-1:0] bin_en;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // Model: accepted {order, word} and its history per drive step.
    logic [DW:0] acc;
    logic [DW:0] pipe [3];

    always #2.5 clk = ~clk;

    segdac_frontend #(.MSB_W(MSB_W), .LSB_W(LSB_W)) dut (
        .clk       (clk),
        .rst       (rst),
        .din_valid (din_valid),
        .din       (din),
        .order_sel (order_sel),
        .unit_en   (unit_en),
        .bin_en    (bin_en)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_unit(input int k, input logic sym);
        logic [N-1:0] v = '0;
        for (int r = 0; r < k; r++) begin
            if (sym) v[SYM_SEQ[r] - 1] = 1'b1;
            else     v[r] = 1'b1;
        end
        return v;
    endfunction

    function automatic int ones(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    // Check outputs against the word accepted three steps ago, then drive.
    task automatic step(input logic v, input logic [DW-1:0] w, input logic o, input string ph);
        int k;
        logic s;
        @(negedge clk);
        k = int'(pipe[2][DW-1:LSB_W]);
        s = pipe[2][DW];
        chk(unit_en == exp_unit(k, s), $sformatf("%s %s R6 unit pattern", s ? "R4" : "R3", ph),
            int'(unit_en), int'(exp_unit(k, s)));
        chk(ones(unit_en) == k, $sformatf("R2 %s count", ph), ones(unit_en), k);
        chk(bin_en == pipe[2][LSB_W-1:0], $sformatf("R5 %s R6 binary", ph),
            int'(bin_en), int'(pipe[2][LSB_W-1:0]));
        din_valid = v;
        din       = w;
        order_sel = o;
        if (v) acc = {o, w};
        pipe[2] = pipe[1];
        pipe[1] = pipe[0];
        pipe[0] = acc;
    endtask

    task automatic model_clear();
        acc = '0;
        for (int i = 0; i < 3; i++) pipe[i] = '0;
    endtask

    initial begin
        rst = 1'b1;
        din_valid = 1'b0;
        din = '0;
        order_sel = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        chk(unit_en == '0 && bin_en == '0, "R1 reset state",
            int'({unit_en, bin_en}), 0);
        rst = 1'b0;

        // Full sweep, ascending order.
        for (int w = 0; w < 64; w++) step(1'b1, DW'(w), 1'b0, "seq sweep");
        // Full sweep, centre-out order, descending words.
        for (int w = 63; w >= 0; w--) step(1'b1, DW'(w), 1'b1, "sym sweep");

        // R7 / R8: hold with changing data and order selection.
        step(1'b1, 6'b101_110, 1'b1, "R7 load");
        for (int i = 0; i < 6; i++)
            step(1'b0, DW'(i * 11 + 3), 1'(i % 2), "R7 R8 hold");

        // Order flips every word, extremes.
        step(1'b1, 6'b111_000, 1'b0, "mix");
        step(1'b1, 6'b111_111, 1'b1, "mix");
        step(1'b1, 6'b000_111, 1'b1, "mix");
        step(1'b1, 6'b001_010, 1'b1, "mix");
        step(1'b1, 6'b110_101, 1'b1, "mix");
        step(1'b1, 6'b110_101, 1'b0, "mix");

        // Reset in mid-stream clears outputs after one edge.
        @(negedge clk);
        rst = 1'b1;
        din_valid = 1'b0;
        @(negedge clk);
        chk(unit_en == '0 && bin_en == '0, "R1 mid-run reset",
            int'({unit_en, bin_en}), 0);
        rst = 1'b0;
        model_clear();

        for (int i = 0; i < 4; i++) step(1'b0, 6'b111_111, 1'b1, "R1 R7 post-reset");
        step(1'b1, 6'b100_001, 1'b1, "post-reset");
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0, "drain");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule